// File: doc/BRIEF.md
# Nonlinear Template Weight Lookup

This block supplies the three weights of one template row to the state-update arithmetic of a cellular-network emulator. The weights are not fixed constants. For each column, the block subtracts that column's neighbour value from the centre cell value. The top bits of this difference pick one segment of a piecewise-constant function. The row index and the segment index together address a small weight RAM, and each template column has its own RAM. All three columns are served in one clock, and a new neighbourhood row can be accepted every clock.

The centre value and the neighbour values travel through a delay line. They come out in the same cycle as the weights that were looked up from them, so the arithmetic downstream sees aligned operands. A host loads the segment values through a simple write port. A write is accepted only while no lookup is in flight, so a weight can never change under a read that is already in progress.

Top module: `nlw_lookup`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid` is 0 and all weight outputs are 0. Every stored segment weight reads as 0 until it is written.
- R2: `out_valid` rises exactly two clock edges after the edge that samples `in_valid` high. It stays low when no lookup was issued.
- R3: The difference for each column is `centre_in - nbr`, computed in two's complement over STATE_W+1 bits. Its SEG_BITS most significant bits are the segment index. With the defaults, a difference of 0..127 gives segment 0, 128..255 gives 1, -256..-129 gives 2, and -128..-1 gives 3.
- R4: Column c reads its own RAM at address `row_sel*2^SEG_BITS + segment`. With the defaults, rows 0, 1 and 2 use addresses 0–3, 4–7 and 8–11. Column c takes its neighbour from bits [c*STATE_W +: STATE_W] of `nbr_in`, and its weight appears at bits [c*WEIGHT_W +: WEIGHT_W] of `weight_out`.
- R5: `centre_out` and `nbr_out` carry the centre and neighbour values of the lookup whose weights are on `weight_out` in the same cycle.
- R6: A host write with `wr_en` high stores `wr_data` at RAM `wr_col`, entry `wr_addr`. The write is ignored when `in_valid` is high in that cycle, and also when a lookup sampled on the previous edge is still in flight.
- R7: A write with `wr_col` ≥ COLS, or with `wr_addr` ≥ ROWS*2^SEG_BITS, changes no stored weight.
- R8: Lookups issued on consecutive cycles each produce their own result on consecutive cycles, in order.
- R9: A lookup with `row_sel` ≥ ROWS returns weight 0 in every column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issues a lookup this cycle |
| centre_in | input | STATE_W | Centre cell value, signed |
| nbr_in | input | COLS*STATE_W | Neighbour values, column c at [c*STATE_W +: STATE_W], signed |
| row_sel | input | ROW_W | Template row index |
| wr_en | input | 1 | Host write strobe |
| wr_col | input | COL_W | Column RAM to write |
| wr_addr | input | ROW_W+SEG_BITS | Entry to write (row*2^SEG_BITS + segment) |
| wr_data | input | WEIGHT_W | Segment weight, signed |
| out_valid | output | 1 | Weights and aligned data are valid |
| weight_out | output | COLS*WEIGHT_W | Looked-up weights, column c at [c*WEIGHT_W +: WEIGHT_W] |
| centre_out | output | STATE_W | Centre value aligned with the weights |
| nbr_out | output | COLS*STATE_W | Neighbour values aligned with the weights |

## Verification
The bench uses the default parameters: an 8-bit state, 9-bit weights, four segments and a 3x3 template. With an 8-bit state the 9-bit difference covers both extremes (127 − (−128) and −128 − 127). Every segment boundary (0, 127/128, −128/−129, 255, −255) can therefore be reached from real cell values. With three rows, the 2-bit row index also has one spare code, which exercises the out-of-range row. The 4-bit entry address likewise has spare codes 12–15, which exercise the rejected writes.

// File: rtl/nlw_pkg.sv
package nlw_pkg;

    // Control carried alongside the addresses in the read stage
    typedef struct packed {
        logic valid;   // lookup in flight
        logic oob;     // row index beyond the template
    } lk_ctl_t;

endpackage

// File: rtl/nlw_seg_index.sv
// Per-column difference and segment address generation (combinational).
module nlw_seg_index #(
    parameter int STATE_W  = 8,
    parameter int SEG_BITS = 2,
    parameter int ROW_W    = 2,
    localparam int ADDR_W  = ROW_W + SEG_BITS
) (
    input  logic [STATE_W-1:0] centre,
    input  logic [STATE_W-1:0] nbr,
    input  logic [ROW_W-1:0]   row,
    output logic [ADDR_W-1:0]  addr
);
    logic [STATE_W:0]          diff;
    logic [SEG_BITS-1:0]       seg;
    logic [STATE_W-SEG_BITS:0] unused_diff_lo;

    always_comb begin
        // sign-extend both operands by one bit so the difference cannot wrap
        diff = {centre[STATE_W-1], centre} - {nbr[STATE_W-1], nbr};
        seg  = diff[STATE_W -: SEG_BITS];
        addr = {row, seg};
    end

    assign unused_diff_lo = diff[STATE_W-SEG_BITS:0];

endmodule

// File: rtl/nlw_seg_ram.sv
// One column's segment-weight store with a registered read port.
module nlw_seg_ram #(
    parameter int WEIGHT_W = 9,
    parameter int ADDR_W   = 4,
    parameter int DEPTH    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_oob,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WEIGHT_W-1:0] wr_data,
    output logic [WEIGHT_W-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][WEIGHT_W-1:0] mem;
        logic [WEIGHT_W-1:0]            rdata;
    } ram_st_t;

    ram_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (rd_oob || int'(rd_addr) >= DEPTH)
                st_d.rdata = '0;
            else
                st_d.rdata = st_q.mem[rd_addr];
        end
        if (wr_en && int'(wr_addr) < DEPTH)
            st_d.mem[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R6: the top never lets a write collide with a read
    a_r6_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en);

    // R9: an out-of-range row reads back as zero
    a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_oob) |=> (rdata == '0));

endmodule

// File: rtl/nlw_pipe_delay.sv
// Fixed-length register delay line for data that must track the lookup.
module nlw_pipe_delay #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++)
            sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/nlw_lookup.sv
// Top: three-column piecewise-constant weight lookup with aligned data.
module nlw_lookup #(
    parameter int  STATE_W  = 8,
    parameter int  WEIGHT_W = 9,
    parameter int  SEG_BITS = 2,
    parameter int  ROWS     = 3,
    parameter int  COLS     = 3,
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ADDR_W   = ROW_W + SEG_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [STATE_W-1:0]       centre_in,
    input  logic [COLS*STATE_W-1:0]  nbr_in,
    input  logic [ROW_W-1:0]         row_sel,
    input  logic                     wr_en,
    input  logic [COL_W-1:0]         wr_col,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WEIGHT_W-1:0]      wr_data,
    output logic                     out_valid,
    output logic [COLS*WEIGHT_W-1:0] weight_out,
    output logic [STATE_W-1:0]       centre_out,
    output logic [COLS*STATE_W-1:0]  nbr_out
);
    import nlw_pkg::*;

    localparam int SEGS    = 1 << SEG_BITS;
    localparam int DEPTH   = ROWS * SEGS;
    localparam int LAT     = 2;  // address register + RAM read register
    localparam int DLY_W   = 1 + STATE_W + COLS * STATE_W;

    typedef struct packed {
        lk_ctl_t                       ctl;
        logic [COLS-1:0][ADDR_W-1:0]   addr;
    } stage_t;

    stage_t                      s1_d, s1_q;
    logic [COLS-1:0][ADDR_W-1:0] addr_c;
    logic                        wr_ok;
    logic [DLY_W-1:0]            dly_in, dly_out;

    // ---------------- per-column address generation and RAMs ----------------
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic col_we;

        nlw_seg_index #(
            .STATE_W (STATE_W),
            .SEG_BITS(SEG_BITS),
            .ROW_W   (ROW_W)
        ) u_idx (
            .centre(centre_in),
            .nbr   (nbr_in[c*STATE_W +: STATE_W]),
            .row   (row_sel),
            .addr  (addr_c[c])
        );

        assign col_we = wr_ok && (int'(wr_col) == c);

        nlw_seg_ram #(
            .WEIGHT_W(WEIGHT_W),
            .ADDR_W  (ADDR_W),
            .DEPTH   (DEPTH)
        ) u_ram (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (s1_q.ctl.valid),
            .rd_addr(s1_q.addr[c]),
            .rd_oob (s1_q.ctl.oob),
            .wr_en  (col_we),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .rdata  (weight_out[c*WEIGHT_W +: WEIGHT_W])
        );
    end

    // ---------------- address stage ----------------
    always_comb begin
        s1_d           = s1_q;
        s1_d.ctl.valid = in_valid;
        s1_d.ctl.oob   = (int'(row_sel) >= ROWS);
        s1_d.addr      = addr_c;
        // host writes only while nothing is being looked up
        wr_ok = wr_en && !in_valid && !s1_q.ctl.valid && (int'(wr_col) < COLS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    // ---------------- data alignment ----------------
    assign dly_in = {in_valid, centre_in, nbr_in};

    nlw_pipe_delay #(
        .W     (DLY_W),
        .STAGES(LAT)
    ) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dly_in),
        .dout (dly_out)
    );

    assign {out_valid, centre_out, nbr_out} = dly_out;

    // ---------------- assertions ----------------
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);

    // R2: a lookup in the read stage reaches the output on the next edge
    a_r2_stage_to_out: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.ctl.valid |=> out_valid);

    // R2: no spurious valid
    a_r2_idle_to_out: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_q.ctl.valid |=> !out_valid);

    // R6: an accepted write is never adjacent to an in-flight lookup
    a_r6_gate_in: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> !(in_valid || s1_q.ctl.valid));

endmodule

// File: tb/nlw_lookup_tb.sv
module nlw_lookup_tb;
    localparam int SW = 8;
    localparam int WW = 9;
    localparam int NC = 3;

    logic            clk = 0;
    logic            rst_n;
    logic            in_valid;
    logic [SW-1:0]   centre_in;
    logic [NC*SW-1:0] nbr_in;
    logic [1:0]      row_sel;
    logic            wr_en;
    logic [1:0]      wr_col;
    logic [3:0]      wr_addr;
    logic [WW-1:0]   wr_data;
    logic            out_valid;
    logic [NC*WW-1:0] weight_out;
    logic [SW-1:0]   centre_out;
    logic [NC*SW-1:0] nbr_out;

    int n_run = 0, n_fail = 0;
    int model [3][12];
    bit done = 0;

    always #2.5 clk = ~clk;

    nlw_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .centre_in(centre_in),
        .nbr_in(nbr_in), .row_sel(row_sel), .wr_en(wr_en), .wr_col(wr_col),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid),
        .weight_out(weight_out), .centre_out(centre_out), .nbr_out(nbr_out)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int seg_of(int c, int n);
        logic [8:0] d;
        d = 9'(c - n);
        return int'(d[8:7]);
    endfunction

    function automatic int exp_w(int col, int c, int n, int row);
        if (row >= 3) return 0;
        return model[col][row*4 + seg_of(c, n)];
    endfunction

    function automatic int wt(int col);
        return int'($signed(weight_out[col*WW +: WW]));
    endfunction

    function automatic int nb(int col);
        return int'($signed(nbr_out[col*SW +: SW]));
    endfunction

    task automatic do_write(int col, int addr, int val);
        @(negedge clk);
        wr_en = 1; wr_col = 2'(col); wr_addr = 4'(addr); wr_data = 9'(val);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic drive(int c, int n0, int n1, int n2, int row);
        in_valid  = 1;
        centre_in = 8'(c);
        nbr_in    = {8'(n2), 8'(n1), 8'(n0)};
        row_sel   = 2'(row);
    endtask

    task automatic check_out(int c, int n0, int n1, int n2, int row, string req);
        int ns [3];
        ns = '{n0, n1, n2};
        chk(out_valid === 1'b1, {req, " R2 valid"}, int'(out_valid), 1);
        chk(int'($signed(centre_out)) == c, {req, " R5 centre"}, int'($signed(centre_out)), c);
        for (int k = 0; k < 3; k++) begin
            chk(nb(k) == ns[k], {req, " R5 nbr"}, nb(k), ns[k]);
            chk(wt(k) == exp_w(k, c, ns[k], row), {req, " R3/R4 weight"}, wt(k), exp_w(k, c, ns[k], row));
        end
    endtask

    task automatic lookup(int c, int n0, int n1, int n2, int row, string req);
        @(negedge clk);
        drive(c, n0, n1, n2, row);
        @(negedge clk);
        in_valid = 0;
        chk(out_valid === 1'b0, {req, " R2 early"}, int'(out_valid), 0);
        @(negedge clk);
        check_out(c, n0, n1, n2, row, req);
    endtask

    // R1: reset state and blank RAM
    task automatic t_reset;
        chk(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(weight_out === '0, "R1 weights in reset", int'(weight_out), 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        lookup(100, -100, 90, 120, 0, "R1 blank RAM");
    endtask

    // R3/R4: example function, all segments and boundaries
    task automatic t_example;
        int tbl [4];
        tbl = '{-1, -2, 2, 1};
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 3; k++) begin
                    int v;
                    v = (r == 1 && k == 1) ? 0 : tbl[s];
                    do_write(k, r*4 + s, v);
                    model[k][r*4 + s] = v;
                end
        lookup(100, -100, 90, 120, 0, "R3 mixed segs");
        lookup(-128, 127, -128, 0, 2, "R3 extremes");
        lookup(127, -128, -1, 126, 1, "R4 middle row centre zero");
        lookup(-128, 1, -1, 127, 0, "R3 -129 boundary");
        lookup(-1, 127, 0, 100, 1, "R3 negative segs");
    endtask

    // R4: distinct values per row reveal row mapping
    task automatic t_rowmap;
        for (int a = 0; a < 12; a++)
            for (int k = 0; k < 3; k++) begin
                do_write(k, a, a*10 + k + 1);
                model[k][a] = a*10 + k + 1;
            end
        for (int r = 0; r < 3; r++) begin
            lookup(5, 0, -5, 100, r, "R4 row map a");
            lookup(-100, 100, 27, -128, r, "R4 row map b");
        end
    endtask

    // R8/R2: back-to-back stream
    task automatic t_stream;
        int cs [6], n0s [6], n1s [6], n2s [6], rs [6];
        cs  = '{10, -50, 127, -128, 0, 64};
        n0s = '{-120, 80, -128, 127, 1, -64};
        n1s = '{10, -50, 0, -1, -128, 64};
        n2s = '{3, 100, 127, 0, 127, -100};
        rs  = '{0, 1, 2, 0, 2, 1};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 2)
                check_out(cs[i-2], n0s[i-2], n1s[i-2], n2s[i-2], rs[i-2], "R8 stream");
            if (i < 6) drive(cs[i], n0s[i], n1s[i], n2s[i], rs[i]);
            else       in_valid = 0;
        end
        @(negedge clk);
        chk(out_valid === 1'b0, "R2 valid drops after stream", int'(out_valid), 1'b0);
    endtask

    // R6: writes during a lookup are ignored
    task automatic t_busy_write;
        @(negedge clk);
        drive(10, 5, 5, 5, 0);
        wr_en = 1; wr_col = 0; wr_addr = 0; wr_data = 9'(77);
        @(negedge clk);
        in_valid = 0;
        wr_col = 1; wr_data = 9'(66);
        @(negedge clk);
        wr_en = 0;
        check_out(10, 5, 5, 5, 0, "R6 busy lookup");
        lookup(10, 5, 5, 5, 0, "R6 write ignored");
    endtask

    // R7: out-of-range write targets
    task automatic t_bad_write;
        do_write(3, 0, 55);
        do_write(0, 12, 55);
        do_write(2, 15, 55);
        lookup(10, 5, 5, 5, 0, "R7 col 3 ignored");
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 0 : (s == 1) ? -128 : (s == 2) ? 127 : 1;
            lookup(0, n, n, n, 2, "R7 addr 12 ignored");
        end
    endtask

    // R9: row index beyond the template
    task automatic t_oob_row;
        lookup(100, -100, 90, 120, 3, "R9 oob row");
        lookup(-5, 0, 0, 0, 3, "R9 oob row b");
    endtask

    initial begin
        rst_n = 0; in_valid = 0; centre_in = '0; nbr_in = '0; row_sel = '0;
        wr_en = 0; wr_col = '0; wr_addr = '0; wr_data = '0;
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 12; a++) model[k][a] = 0;
        repeat (3) @(negedge clk);
        t_reset;
        t_example;
        t_rowmap;
        t_stream;
        t_busy_write;
        t_bad_write;
        t_oob_row;
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule